// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Bridge

This block turns processor bus accesses into I/O port cycles. Any access whose address falls in an 8 MB window starting at 0x8000_0000 is claimed. The offset inside that window is converted into a 16-bit I/O port number, and one request goes out on a request/ready port bus. The conversion has two modes, picked by a map-type input. The contiguous mode takes the low 16 offset bits as they are. The non-contiguous mode gives every 4 KB page of the window 32 ports: it places the page number just above the five lowest offset bits.

Byte, halfword and word accesses are supported. Data is right-justified on both buses. When the big-endian input is set, halfword and word data is byte-swapped in both directions; byte data never is. A separate 4-byte location at 0xBFFF_FFF0 acts as the interrupt-acknowledge read. A read of its first byte returns the vector offered by the interrupt controller and pulses an acknowledge strobe back to it.

The processor holds its request until the bridge returns a one-cycle acknowledge. Addresses outside both regions are not claimed.

Top module: `isa_io_window_bridge`

## Requirements
- R1: An access to an address from 0x8000_0000 to 0x807F_FFFF is claimed and produces exactly one I/O request, carrying the access direction and size.
- R2: With the map-type input at 0 (contiguous), the I/O port number equals address bits 15:0.
- R3: With the map-type input at 1 (non-contiguous), the port number is {address bits 22:12, address bits 4:0}. This is (addr & 0x1F) | ((addr & 0x7FFF000) >> 7) cut to 16 bits, and address bits 11:5 do not affect it.
- R4: With big-endian off, data passes unchanged in both directions. Lanes above the access size are driven as zero. Size code 0 is a byte, 1 a halfword, 2 a word.
- R5: With big-endian on, halfword data has its two bytes exchanged, on writes toward the I/O bus and on reads toward the processor.
- R6: With big-endian on, word data has its four bytes reversed in both directions.
- R7: Byte accesses are never swapped, whatever the big-endian input holds.
- R8: A byte read of exactly 0xBFFF_FFF0 returns the controller's vector, zero-extended. A read of 0xBFFF_FFF1 to 0xBFFF_FFF3 returns 0. Neither read starts an I/O request.
- R9: The acknowledge strobe is high for exactly one cycle per read of 0xBFFF_FFF0, and never for any other access.
- R10: A write to the acknowledge location is acknowledged and has no other effect: no I/O request and no strobe.
- R11: The I/O request stays high, with port and write data held, until ready is sampled high. The processor acknowledge follows one cycle later and lasts one cycle.
- R12: An access outside both regions leaves the claim output low and produces no I/O request and no acknowledge.
- R13: After reset, the I/O request, processor acknowledge and acknowledge strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_noncontig | input | 1 | Port mapping select: 0 contiguous, 1 paged |
| big_endian | input | 1 | Enables byte-lane swapping for halfword and word |
| cpu_req | input | 1 | Processor access request, held until cpu_ack |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_claim | output | 1 | Request hits the window or acknowledge location |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid while cpu_ack is high |
| io_req | output | 1 | I/O cycle request |
| io_we | output | 1 | I/O cycle is a write |
| io_port | output | 16 | I/O port number |
| io_size | output | 2 | I/O access size |
| io_wdata | output | 32 | I/O write data, lane-adjusted |
| io_ready | input | 1 | I/O side completes the cycle |
| io_rdata | input | 32 | I/O read data, sampled with io_ready |
| iack_vector | input | 8 | Vector offered by the interrupt controller |
| iack_strobe | output | 1 | One-cycle pulse on a vector read |

## Verification
The hardest case to reach from the ports is an I/O cycle that stalls for several cycles. The port and data must hold steady throughout, and the acknowledge must land exactly one cycle after ready. The bench's I/O responder withholds ready for a programmable number of cycles and compares the port against its first sampled value in every stalled cycle. The paged mapping needs addresses whose offset bits 11:5 are non-zero, to show that those bits are dropped. The top of the window is used to reach the highest port.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_IO   = 2'b01,
      ST_DONE = 2'b10
   } br_state_e;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
   parameter int                ADDR_W        = 32,
   parameter int                PORT_W        = 16,
   parameter int                WIN_SPAN_BITS = 23,
   parameter int                PAGE_BITS     = 12,
   parameter int                LOW_BITS      = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] IACK_ADDR     = 32'hBFFF_FFF0,
   parameter bit                NONCONTIG_EN  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              noncontig,
   output logic              win_hit,
   output logic              iack_hit,
   output logic              iack_exact,
   output logic [PORT_W-1:0] port
);
   localparam int PG_W = PORT_W - LOW_BITS;

   assign win_hit    = (addr[ADDR_W-1:WIN_SPAN_BITS] == WIN_BASE[ADDR_W-1:WIN_SPAN_BITS]);
   assign iack_hit   = (addr[ADDR_W-1:2] == IACK_ADDR[ADDR_W-1:2]);
   assign iack_exact = (addr[1:0] == IACK_ADDR[1:0]) && iack_hit;

   logic [PORT_W-1:0] port_flat;
   assign port_flat = addr[PORT_W-1:0];

   generate
      if (NONCONTIG_EN) begin : g_paged
         logic [PORT_W-1:0] port_paged;
         assign port_paged = {addr[PAGE_BITS+PG_W-1:PAGE_BITS], addr[LOW_BITS-1:0]};
         assign port = noncontig ? port_paged : port_flat;
      end else begin : g_flat_only
         assign port = port_flat;
      end
   endgenerate

endmodule

// File: rtl/iowin_lane_swap.sv
module iowin_lane_swap #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        size,
   input  logic              swap_en,
   output logic [DATA_W-1:0] dout
);
   import iowin_pkg::*;

   localparam int NB = DATA_W / 8;

   logic [DATA_W-1:0] rev;

   genvar g;
   generate
      for (g = 0; g < NB; g++) begin : g_lane
         assign rev[8*g +: 8] = din[8*(NB-1-g) +: 8];
      end
   endgenerate

   always_comb begin
      dout = '0;
      case (size)
         SZ_BYTE: dout[7:0]  = din[7:0];
         SZ_HALF: dout[15:0] = swap_en ? {din[7:0], din[15:8]} : din[15:0];
         default: dout       = swap_en ? rev : din;
      endcase
   end

endmodule

// File: rtl/iowin_seq.sv
module iowin_seq #(
   parameter int PORT_W = 16,
   parameter int DATA_W = 32,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic              win_hit,
   input  logic              iack_hit,
   input  logic              iack_exact,
   input  logic [PORT_W-1:0] port_in,
   input  logic [DATA_W-1:0] wdata_sw,
   input  logic [VEC_W-1:0]  vector,
   input  logic              io_ready,
   input  logic [DATA_W-1:0] io_rdata,
   output logic              io_req,
   output logic              io_we,
   output logic [PORT_W-1:0] io_port,
   output logic [1:0]        io_size,
   output logic [DATA_W-1:0] io_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] rdata_raw,
   output logic              iack_strobe
);
   import iowin_pkg::*;

   br_state_e         state_q;
   logic [PORT_W-1:0] port_q;
   logic              we_q;
   logic [1:0]        size_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         port_q   <= '0;
         we_q     <= 1'b0;
         size_q   <= SZ_BYTE;
         wdata_q  <= '0;
         rdata_q  <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (cpu_req && win_hit) begin
                  state_q <= ST_IO;
                  port_q  <= port_in;
                  we_q    <= cpu_we;
                  size_q  <= cpu_size;
                  wdata_q <= wdata_sw;
                  rdata_q <= '0;
               end else if (cpu_req && iack_hit) begin
                  state_q  <= ST_DONE;
                  size_q   <= cpu_size;
                  rdata_q  <= (!cpu_we && iack_exact) ?
                              {{(DATA_W-VEC_W){1'b0}}, vector} : '0;
                  strobe_q <= !cpu_we && iack_exact;
               end
            end
            ST_IO: begin
               if (io_ready) begin
                  state_q <= ST_DONE;
                  if (!we_q) rdata_q <= io_rdata;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign io_req      = (state_q == ST_IO);
   assign cpu_ack     = (state_q == ST_DONE);
   assign io_we       = we_q;
   assign io_port     = port_q;
   assign io_size     = size_q;
   assign io_wdata    = wdata_q;
   assign rdata_raw   = rdata_q;
   assign iack_strobe = strobe_q;

endmodule

// File: rtl/isa_io_window_bridge.sv
module isa_io_window_bridge #(
   parameter int                ADDR_W        = 32,
   parameter int                DATA_W        = 32,
   parameter int                PORT_W        = 16,
   parameter int                VEC_W         = 8,
   parameter int                WIN_SPAN_BITS = 23,
   parameter int                PAGE_BITS     = 12,
   parameter int                LOW_BITS      = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] IACK_ADDR     = 32'hBFFF_FFF0,
   parameter bit                NONCONTIG_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_noncontig,
   input  logic              big_endian,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_claim,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              io_req,
   output logic              io_we,
   output logic [PORT_W-1:0] io_port,
   output logic [1:0]        io_size,
   output logic [DATA_W-1:0] io_wdata,
   input  logic              io_ready,
   input  logic [DATA_W-1:0] io_rdata,
   input  logic [VEC_W-1:0]  iack_vector,
   output logic              iack_strobe
);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (LOW_BITS >= PORT_W) begin : g_bad_low_bits
         $error("LOW_BITS must be smaller than PORT_W");
      end
      if (PAGE_BITS + PORT_W - LOW_BITS > WIN_SPAN_BITS) begin : g_bad_span
         $error("paged port field reaches beyond the window");
      end
      if (VEC_W > DATA_W) begin : g_bad_vec_w
         $error("VEC_W must not exceed DATA_W");
      end
   endgenerate

   logic              win_hit;
   logic              iack_hit;
   logic              iack_exact;
   logic [PORT_W-1:0] port_map;
   logic [DATA_W-1:0] wdata_sw;
   logic [DATA_W-1:0] rdata_raw;

   iowin_decode #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_SPAN_BITS(WIN_SPAN_BITS),
      .PAGE_BITS(PAGE_BITS), .LOW_BITS(LOW_BITS), .WIN_BASE(WIN_BASE),
      .IACK_ADDR(IACK_ADDR), .NONCONTIG_EN(NONCONTIG_EN)
   ) i_decode (
      .addr(cpu_addr), .noncontig(map_noncontig), .win_hit(win_hit),
      .iack_hit(iack_hit), .iack_exact(iack_exact), .port(port_map)
   );

   iowin_lane_swap #(.DATA_W(DATA_W)) i_wr_swap (
      .din(cpu_wdata), .size(cpu_size), .swap_en(big_endian), .dout(wdata_sw)
   );

   iowin_seq #(.PORT_W(PORT_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_size(cpu_size), .win_hit(win_hit), .iack_hit(iack_hit),
      .iack_exact(iack_exact), .port_in(port_map), .wdata_sw(wdata_sw),
      .vector(iack_vector), .io_ready(io_ready), .io_rdata(io_rdata),
      .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_size(io_size),
      .io_wdata(io_wdata), .cpu_ack(cpu_ack), .rdata_raw(rdata_raw),
      .iack_strobe(iack_strobe)
   );

   iowin_lane_swap #(.DATA_W(DATA_W)) i_rd_swap (
      .din(rdata_raw), .size(io_size), .swap_en(big_endian), .dout(cpu_rdata)
   );

   assign cpu_claim = cpu_req && (win_hit || iack_hit);

endmodule

// File: rtl/iowin_bridge_chk.sv
module iowin_bridge_chk #(
   parameter int                ADDR_W        = 32,
   parameter int                DATA_W        = 32,
   parameter int                PORT_W        = 16,
   parameter int                WIN_SPAN_BITS = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] IACK_ADDR     = 32'hBFFF_FFF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_claim,
   input logic              cpu_ack,
   input logic              io_req,
   input logic              io_we,
   input logic [PORT_W-1:0] io_port,
   input logic [1:0]        io_size,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_ready,
   input logic              iack_strobe
);

   assert_io_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_req) |-> $past(cpu_req &&
         cpu_addr[ADDR_W-1:WIN_SPAN_BITS] == WIN_BASE[ADDR_W-1:WIN_SPAN_BITS]));

   assert_byte_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(io_req) && io_we && io_size == 2'b00) |->
         io_wdata[7:0] == $past(cpu_wdata[7:0]));

   assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      iack_strobe |-> $past(cpu_req && !cpu_we && cpu_addr == IACK_ADDR));

   assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      iack_strobe |=> !iack_strobe);

   assert_iack_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && cpu_addr[ADDR_W-1:2] == IACK_ADDR[ADDR_W-1:2] &&
       !io_req && !cpu_ack) |=> (!io_req && !iack_strobe));

   assert_io_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_ready) |=> (io_req && $stable(io_port) && $stable(io_wdata)));

   assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

   assert_no_claim_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_claim && !io_req && !cpu_ack) |=> (!io_req && !cpu_ack));

endmodule

bind isa_io_window_bridge iowin_bridge_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
   .WIN_SPAN_BITS(WIN_SPAN_BITS), .WIN_BASE(WIN_BASE), .IACK_ADDR(IACK_ADDR)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_claim(cpu_claim),
   .cpu_ack(cpu_ack), .io_req(io_req), .io_we(io_we), .io_port(io_port),
   .io_size(io_size), .io_wdata(io_wdata), .io_ready(io_ready),
   .iack_strobe(iack_strobe)
);

// File: tb/test_isa_io_window_bridge.sv
module test_isa_io_window_bridge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_noncontig = 1'b0;
   logic        big_endian = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_claim;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        io_req;
   logic        io_we;
   logic [15:0] io_port;
   logic [1:0]  io_size;
   logic [31:0] io_wdata;
   logic        io_ready = 1'b0;
   logic [31:0] io_rdata = '0;
   logic [7:0]  iack_vector = 8'h47;
   logic        iack_strobe;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   isa_io_window_bridge i_isa_io_window_bridge (
      .clk(clk), .rst_n(rst_n), .map_noncontig(map_noncontig),
      .big_endian(big_endian), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_claim(cpu_claim), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_size(io_size),
      .io_wdata(io_wdata), .io_ready(io_ready), .io_rdata(io_rdata),
      .iack_vector(iack_vector), .iack_strobe(iack_strobe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // Result of the last access
   logic [31:0] r_rdata, r_iow;
   logic [15:0] r_port;
   logic [1:0]  r_size;
   logic        r_iowe;
   bit          r_claim, r_io, r_ack, r_stable;
   int          r_strobes, r_io_reqs;

   task automatic access(input bit we, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input int lat, input logic [31:0] rd);
      int waited = 0;
      bit prev_io = 1'b0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
      r_io = 0; r_ack = 0; r_stable = 1; r_strobes = 0; r_io_reqs = 0;
      r_rdata = 'x; r_port = 'x; r_iow = 'x; r_size = 'x; r_iowe = 1'bx;
      #1 r_claim = cpu_claim;
      for (int c = 0; c < 20 && !r_ack; c++) begin
         @(negedge clk);
         if (iack_strobe) r_strobes++;
         if (io_req && !prev_io) r_io_reqs++;
         prev_io = io_req;
         if (cpu_ack) begin
            r_ack = 1; r_rdata = cpu_rdata;
         end else if (io_req && !io_ready) begin
            if (!r_io) begin
               r_io = 1; r_port = io_port; r_iow = io_wdata;
               r_size = io_size; r_iowe = io_we;
            end else if (io_port !== r_port || io_wdata !== r_iow) r_stable = 0;
            if (waited == lat) begin io_ready = 1'b1; io_rdata = rd; end
            else waited++;
         end else if (io_ready) io_ready = 1'b0;
      end
      cpu_req = 1'b0; io_ready = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R13 io_req", {31'b0, io_req}, 32'd0);
      check("R13 cpu_ack", {31'b0, cpu_ack}, 32'd0);
      check("R13 iack_strobe", {31'b0, iack_strobe}, 32'd0);
   endtask

   task automatic t_contig();
      map_noncontig = 1'b0; big_endian = 1'b0;
      access(1'b0, 32'h8000_1234, 2'd0, '0, 0, 32'hFFFF_FF5A);
      check("R1 claim", {31'b0, r_claim}, 32'd1);
      check("R1 one io request", r_io_reqs, 32'd1);
      check("R1 io_we read", {31'b0, r_iowe}, 32'd0);
      check("R2 port", {16'b0, r_port}, 32'h1234);
      check("R4 byte read upper zero", r_rdata, 32'h0000_005A);
      access(1'b1, 32'h807F_FFFC, 2'd2, 32'h1122_3344, 0, '0);
      check("R2 port top", {16'b0, r_port}, 32'hFFFC);
      check("R1 size word", {30'b0, r_size}, 32'd2);
      check("R4 word write", r_iow, 32'h1122_3344);
      access(1'b0, 32'h8000_0060, 2'd1, '0, 0, 32'hFFFF_ABCD);
      check("R4 half read", r_rdata, 32'h0000_ABCD);
   endtask

   task automatic t_noncontig();
      map_noncontig = 1'b1; big_endian = 1'b0;
      access(1'b0, 32'h8012_345F, 2'd0, '0, 0, 32'h1);
      check("R3 paged port", {16'b0, r_port}, 32'h247F);
      access(1'b1, 32'h807F_F01F, 2'd0, 32'h99, 0, '0);
      check("R3 paged port top", {16'b0, r_port}, 32'hFFFF);
      access(1'b1, 32'h8000_2FE3, 2'd0, 32'h99, 0, '0);
      check("R3 bits 11:5 dropped", {16'b0, r_port}, 32'h0043);
      map_noncontig = 1'b0;
   endtask

   task automatic t_swap();
      big_endian = 1'b1;
      access(1'b1, 32'h8000_0070, 2'd1, 32'h0000_1234, 0, '0);
      check("R5 half write swap", r_iow, 32'h0000_3412);
      access(1'b0, 32'h8000_0070, 2'd1, '0, 0, 32'h0000_ABCD);
      check("R5 half read swap", r_rdata, 32'h0000_CDAB);
      access(1'b1, 32'h8000_0080, 2'd2, 32'h1122_3344, 0, '0);
      check("R6 word write reverse", r_iow, 32'h4433_2211);
      access(1'b0, 32'h8000_0080, 2'd2, '0, 0, 32'hA1B2_C3D4);
      check("R6 word read reverse", r_rdata, 32'hD4C3_B2A1);
      access(1'b1, 32'h8000_0090, 2'd0, 32'h0000_00C3, 0, '0);
      check("R7 byte write unswapped", r_iow, 32'h0000_00C3);
      access(1'b0, 32'h8000_0090, 2'd0, '0, 0, 32'h0000_007E);
      check("R7 byte read unswapped", r_rdata, 32'h0000_007E);
      big_endian = 1'b0;
   endtask

   task automatic t_iack();
      iack_vector = 8'h47;
      access(1'b0, 32'hBFFF_FFF0, 2'd0, '0, 0, '0);
      check("R8 vector", r_rdata, 32'h0000_0047);
      check("R8 no io", {31'b0, r_io}, 32'd0);
      check("R9 strobe count", r_strobes, 32'd1);
      check("R9 strobe low after", {31'b0, iack_strobe}, 32'd0);
      access(1'b0, 32'hBFFF_FFF2, 2'd0, '0, 0, '0);
      check("R8 other byte zero", r_rdata, 32'd0);
      check("R9 no strobe other byte", r_strobes, 32'd0);
      access(1'b0, 32'h8000_0010, 2'd0, '0, 0, 32'h5);
      check("R9 no strobe on window read", r_strobes, 32'd0);
   endtask

   task automatic t_iack_write();
      access(1'b1, 32'hBFFF_FFF0, 2'd0, 32'h55, 0, '0);
      check("R10 acked", {31'b0, r_ack}, 32'd1);
      check("R10 no io", {31'b0, r_io}, 32'd0);
      check("R10 no strobe", r_strobes, 32'd0);
   endtask

   task automatic t_handshake();
      access(1'b0, 32'h8000_03F8, 2'd0, '0, 3, 32'h0000_00E1);
      check("R11 held while stalled", {31'b0, r_stable}, 32'd1);
      check("R11 read data after stall", r_rdata, 32'h0000_00E1);
      check("R11 ack low afterwards", {31'b0, cpu_ack}, 32'd0);
   endtask

   task automatic t_unclaimed();
      access(1'b0, 32'h8080_0000, 2'd0, '0, 0, '0);
      check("R12 claim above window", {31'b0, r_claim}, 32'd0);
      check("R12 no io", {31'b0, r_io}, 32'd0);
      check("R12 no ack", {31'b0, r_ack}, 32'd0);
      access(1'b0, 32'hBFFF_FFEC, 2'd0, '0, 0, '0);
      check("R12 claim below iack", {31'b0, r_claim}, 32'd0);
      check("R12 no ack near iack", {31'b0, r_ack}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_contig();
      t_noncontig();
      t_swap();
      t_iack();
      t_iack_write();
      t_handshake();
      t_unclaimed();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule